// File: doc/BRIEF.md
# Signed Fixed-Point Narrowing Unit

This unit takes a signed two's-complement word and narrows it in two steps. First a fixed number of fraction bits is dropped at the bottom. One of eight rounding modes, picked on a 3-bit select, decides the rounding. The rounded value is one bit wider than the kept integer part, because several modes can carry into a new top bit.

The rounded value is then fitted to the output width. If the output is narrower, the unit either saturates to the nearest representable code or simply keeps the low bits (trim). If the output is wider, the value is sign-extended. An optional symmetric clamp, enabled per word, replaces the most negative output code with its neighbour, so the range becomes balanced around zero.

An overflow flag marks every word whose value was altered by saturation or by the symmetric clamp. The datapath is combinational. A parameter adds a single output register stage.

Top module: `fxr_narrow`

## Requirements
- R1: Mode codes 0..3 on `mode` select directed rounding of the dropped bits. 0 rounds toward minus infinity. 1 rounds toward zero. 2 rounds toward plus infinity. 3 rounds away from zero. When the dropped bits are all zero, the kept value is unchanged.
- R2: Mode codes 4..7 round to the nearest value. The top dropped bit is the half bit, and the OR of the lower dropped bits is the sticky bit. An exact half is resolved per mode. Code 4 resolves upward and code 5 downward. Code 6 resolves toward zero and code 7, the conventional default, away from zero.
- R3: With the output width equal to IN_W-DROP and saturation selected, modes 0 and 1 never raise `ovf` while `sym_en` is low.
- R4: With the output width equal to IN_W-DROP+1, every mode returns the exact rounded value, with the carry kept, and `ovf` stays low while `sym_en` is low.
- R5: When saturation is selected and the rounded value is above the signed maximum or below the signed minimum of OUT_W bits, `dout` takes that maximum or minimum and `ovf` is 1.
- R6: At an output width of IN_W-DROP with saturation, the result equals the carry-keeping result of R4 clamped to one bit fewer.
- R7: With trim selected, `dout` is the low OUT_W bits of the rounded value, read as signed. `ovf` is raised only by the symmetric clamp.
- R8: When OUT_W exceeds IN_W-DROP+1, the rounded value is sign-extended into `dout` and `ovf` stays low while `sym_en` is low.
- R9: With `sym_en` high, an output code equal to the most negative OUT_W-bit value is replaced by that value plus one and `ovf` is 1. With `sym_en` low, the most negative code passes unchanged.
- R10: With REG_OUT=1, `dout` and `ovf` reflect the inputs present at the previous rising clock edge. A synchronous active-high `rst` drives both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| din | input | IN_W | Signed input word; its low DROP bits are the fraction to remove |
| mode | input | 3 | Rounding mode code 0..7 |
| sym_en | input | 1 | Enables the symmetric clamp of the most negative code |
| dout | output | OUT_W | Signed narrowed result |
| ovf | output | 1 | Result altered by saturation or symmetric clamp |

## Verification
Saturation and the symmetric clamp can both act on one word. A negative value that saturates to the minimum code is moved up again by the clamp. The bench provokes this by driving the most negative inputs with `sym_en` high into the narrow saturating instance. It requires the result to be minimum plus one, with a single `ovf`, and it compares every instance against an integer model that applies saturation first and the clamp second. The same sweeps also cover rounding carries that push a value just past the maximum code.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

    typedef enum logic [2:0] {
        RM_FLOOR      = 3'd0,
        RM_FLOOR_ZERO = 3'd1,
        RM_CEIL       = 3'd2,
        RM_CEIL_AWAY  = 3'd3,
        RM_HALF_UP    = 3'd4,
        RM_HALF_DOWN  = 3'd5,
        RM_HALF_ZERO  = 3'd6,
        RM_HALF_AWAY  = 3'd7
    } rnd_mode_e;

    // Summary of the bits being dropped plus the input sign
    typedef struct packed {
        logic neg;     // input is negative
        logic any;     // any dropped bit set
        logic half;    // top dropped bit
        logic sticky;  // OR of dropped bits below the half bit
    } frac_info_t;

    // Increment to apply to the floor quotient (R1, R2)
    function automatic logic round_inc(input rnd_mode_e m, input frac_info_t f);
        logic inc;
        case (m)
            RM_FLOOR:      inc = 1'b0;
            RM_FLOOR_ZERO: inc = f.neg & f.any;
            RM_CEIL:       inc = f.any;
            RM_CEIL_AWAY:  inc = ~f.neg & f.any;
            RM_HALF_UP:    inc = f.half;
            RM_HALF_DOWN:  inc = f.half & f.sticky;
            RM_HALF_ZERO:  inc = f.half & (f.sticky | f.neg);
            RM_HALF_AWAY:  inc = f.half & (f.sticky | ~f.neg);
            default:       inc = 1'b0;
        endcase
        return inc;
    endfunction

endpackage

// File: rtl/fxr_round.sv
module fxr_round
    import fxr_pkg::*;
#(
    parameter int IN_W = 16,
    parameter int DROP = 6,
    localparam int QW  = IN_W - DROP,
    localparam int RW  = QW + 1
) (
    input  logic [IN_W-1:0] din,
    input  rnd_mode_e       mode,
    output logic [RW-1:0]   rnd
);
    logic [QW-1:0] quo;
    frac_info_t    info;
    logic          inc;

    assign quo       = din[IN_W-1:DROP];
    assign info.neg  = din[IN_W-1];
    assign info.any  = |din[DROP-1:0];
    assign info.half = din[DROP-1];

    generate
        if (DROP > 1) begin : g_sticky
            assign info.sticky = |din[DROP-2:0];
        end else begin : g_no_sticky
            assign info.sticky = 1'b0;
        end
    endgenerate

    assign inc = round_inc(mode, info);
    assign rnd = {quo[QW-1], quo} + {{(RW-1){1'b0}}, inc};

endmodule

// File: rtl/fxr_fit.sv
module fxr_fit #(
    parameter int RW    = 11,
    parameter int OUT_W = 10,
    parameter bit SAT   = 1'b1
) (
    input  logic [RW-1:0]    val,
    output logic [OUT_W-1:0] res,
    output logic             clip
);
    generate
        if (OUT_W >= RW) begin : g_extend
            assign res  = OUT_W'($signed(val));
            assign clip = 1'b0;
        end else if (SAT) begin : g_sat
            localparam int TW = RW - OUT_W + 1;
            logic [TW-1:0] top;
            logic          fits;
            assign top  = val[RW-1:OUT_W-1];
            assign fits = (&top) | ~(|top);
            always_comb begin
                if (fits) begin
                    res  = val[OUT_W-1:0];
                    clip = 1'b0;
                end else begin
                    res  = val[RW-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                                     : {1'b0, {(OUT_W-1){1'b1}}};
                    clip = 1'b1;
                end
            end
        end else begin : g_trim
            logic unused_hi;
            assign unused_hi = ^val[RW-1:OUT_W];
            assign res  = val[OUT_W-1:0];
            assign clip = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/fxr_sym.sv
module fxr_sym #(
    parameter int W = 10
) (
    input  logic [W-1:0] a,
    input  logic         en,
    output logic [W-1:0] y,
    output logic         hit
);
    localparam logic [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};

    assign hit = en && (a == MIN_CODE);
    assign y   = hit ? MIN_CODE + W'(1) : a;

endmodule

// File: rtl/fxr_narrow.sv
module fxr_narrow
    import fxr_pkg::*;
#(
    parameter int IN_W    = 16,
    parameter int DROP    = 6,
    parameter int OUT_W   = 10,
    parameter bit SAT     = 1'b1,
    parameter bit REG_OUT = 1'b1,
    localparam int RW     = IN_W - DROP + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  din,
    input  logic [2:0]       mode,
    input  logic             sym_en,
    output logic [OUT_W-1:0] dout,
    output logic             ovf
);
    logic [RW-1:0]    rnd;
    logic [OUT_W-1:0] fit_v;
    logic             fit_clip;
    logic [OUT_W-1:0] sym_v;
    logic             sym_hit;
    logic             ovf_c;

    fxr_round #(.IN_W(IN_W), .DROP(DROP)) u_round (
        .din  (din),
        .mode (rnd_mode_e'(mode)),
        .rnd  (rnd)
    );

    fxr_fit #(.RW(RW), .OUT_W(OUT_W), .SAT(SAT)) u_fit (
        .val  (rnd),
        .res  (fit_v),
        .clip (fit_clip)
    );

    fxr_sym #(.W(OUT_W)) u_sym (
        .a   (fit_v),
        .en  (sym_en),
        .y   (sym_v),
        .hit (sym_hit)
    );

    assign ovf_c = fit_clip | sym_hit;

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    dout <= '0;
                    ovf  <= 1'b0;
                end else begin
                    dout <= sym_v;
                    ovf  <= ovf_c;
                end
            end
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst;
            assign dout = sym_v;
            assign ovf  = ovf_c;
        end
    endgenerate

endmodule

// File: rtl/fxr_narrow_chk.sv
module fxr_narrow_chk #(
    parameter int IN_W    = 16,
    parameter int DROP    = 6,
    parameter int OUT_W   = 10,
    parameter bit SAT     = 1'b1,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [IN_W-1:0]  din,
    input logic [2:0]       mode,
    input logic             sym_en,
    input logic [OUT_W-1:0] dout,
    input logic             ovf
);
    localparam int QW = IN_W - DROP;
    localparam logic [OUT_W-1:0] MIN_C = {1'b1, {(OUT_W-1){1'b0}}};
    localparam logic [OUT_W-1:0] MAX_C = {1'b0, {(OUT_W-1){1'b1}}};

    logic [IN_W-1:0] d_din;
    logic [2:0]      d_mode;
    logic            d_sym;

    generate
        if (REG_OUT) begin : g_dly
            always_ff @(posedge clk) begin
                if (rst) begin
                    d_din  <= '0;
                    d_mode <= '0;
                    d_sym  <= 1'b0;
                end else begin
                    d_din  <= din;
                    d_mode <= mode;
                    d_sym  <= sym_en;
                end
            end
        end else begin : g_now
            assign d_din  = din;
            assign d_mode = mode;
            assign d_sym  = sym_en;
        end
    endgenerate

    // R9: the most negative code never leaves while the clamp is on
    assert_sym_no_min_R9: assert property (@(posedge clk) disable iff (rst)
        d_sym |-> (dout != MIN_C));

    // R5: a flagged word sits at a limit (or at minimum plus one after clamp)
    assert_ovf_at_limit_R5: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (dout == MAX_C || dout == MIN_C || (d_sym && dout == MIN_C + OUT_W'(1))));

    generate
        if (OUT_W >= QW && SAT) begin : g_floor_chk
            logic signed [IN_W-1:0] fl;
            assign fl = $signed(d_din) >>> DROP;

            // R3: floor-type modes need no carry
            assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
                (d_mode <= 3'd1 && !d_sym) |-> !ovf);

            // R1: floor mode yields the arithmetic shift of the input
            assert_floor_shift_R1: assert property (@(posedge clk) disable iff (rst)
                (d_mode == 3'd0 && !d_sym) |-> (dout == OUT_W'(fl)));
        end
        if (!SAT) begin : g_trim_chk
            // R7: trim never flags on its own
            assert_trim_no_flag_R7: assert property (@(posedge clk) disable iff (rst)
                !d_sym |-> !ovf);
        end
    endgenerate

endmodule

bind fxr_narrow fxr_narrow_chk #(
    .IN_W(IN_W), .DROP(DROP), .OUT_W(OUT_W), .SAT(SAT), .REG_OUT(REG_OUT)
) u_chk (
    .clk(clk), .rst(rst), .din(din), .mode(mode), .sym_en(sym_en),
    .dout(dout), .ovf(ovf)
);

// File: tb/fxr_narrow_bench.sv
`timescale 1ns/1ps
module fxr_narrow_bench;
    localparam int IN_W = 16;
    localparam int DROP = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [IN_W-1:0] din = '0;
    logic [2:0] mode = 3'd7;
    logic sym_en = 1'b0;

    logic [9:0]  dout_a;  logic ovf_a;   // aligned, saturating (10 bits)
    logic [10:0] dout_w;  logic ovf_w;   // carry kept (11 bits)
    logic [12:0] dout_e;  logic ovf_e;   // sign-extended (13 bits)
    logic [7:0]  dout_n;  logic ovf_n;   // narrow saturating (8 bits)
    logic [7:0]  dout_t;  logic ovf_t;   // narrow trimming (8 bits)

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    fxr_narrow #(.IN_W(IN_W), .DROP(DROP), .OUT_W(10), .SAT(1'b1)) u_fxr_narrow (
        .clk(clk), .rst(rst), .din(din), .mode(mode), .sym_en(sym_en), .dout(dout_a), .ovf(ovf_a));
    fxr_narrow #(.IN_W(IN_W), .DROP(DROP), .OUT_W(11), .SAT(1'b1)) u_fxr_narrow_wide (
        .clk(clk), .rst(rst), .din(din), .mode(mode), .sym_en(sym_en), .dout(dout_w), .ovf(ovf_w));
    fxr_narrow #(.IN_W(IN_W), .DROP(DROP), .OUT_W(13), .SAT(1'b1)) u_fxr_narrow_ext (
        .clk(clk), .rst(rst), .din(din), .mode(mode), .sym_en(sym_en), .dout(dout_e), .ovf(ovf_e));
    fxr_narrow #(.IN_W(IN_W), .DROP(DROP), .OUT_W(8), .SAT(1'b1)) u_fxr_narrow_sat8 (
        .clk(clk), .rst(rst), .din(din), .mode(mode), .sym_en(sym_en), .dout(dout_n), .ovf(ovf_n));
    fxr_narrow #(.IN_W(IN_W), .DROP(DROP), .OUT_W(8), .SAT(1'b0)) u_fxr_narrow_trim (
        .clk(clk), .rst(rst), .din(din), .mode(mode), .sym_en(sym_en), .dout(dout_t), .ovf(ovf_t));

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Integer model of rounding (R1, R2)
    function automatic int rnd_ref(input int v, input int m);
        int p, q, rem, h;
        p = 1 << DROP;
        h = p / 2;
        q = (v >= 0) ? v / p : -((-v + p - 1) / p);
        rem = v - q * p;
        if (rem == 0) return q;
        case (m)
            0: return q;
            1: return (v < 0) ? q + 1 : q;
            2: return q + 1;
            3: return (v < 0) ? q : q + 1;
            4: return (rem >= h) ? q + 1 : q;
            5: return (rem > h) ? q + 1 : q;
            6: return (rem > h || (rem == h && v < 0)) ? q + 1 : q;
            default: return (rem > h || (rem == h && v >= 0)) ? q + 1 : q;
        endcase
    endfunction

    // Integer model of fitting and clamp (R5, R7, R9)
    task automatic fit_ref(input int r, input int ow, input bit sat, input bit sym,
                           output int y, output int o);
        int mx, mn;
        mx = (1 << (ow - 1)) - 1;
        mn = -(1 << (ow - 1));
        o = 0;
        if (sat) begin
            if (r > mx) begin y = mx; o = 1; end
            else if (r < mn) begin y = mn; o = 1; end
            else y = r;
        end else begin
            y = r & ((1 << ow) - 1);
            if (y > mx) y = y - (1 << ow);
        end
        if (sym && y == mn) begin y = mn + 1; o = 1; end
    endtask

    task automatic run_vec(input int v, input int m, input bit s);
        int r, y, o, cw;
        string rq;
        @(negedge clk);
        din = IN_W'(v);
        mode = 3'(m);
        sym_en = s;
        @(negedge clk);
        r  = rnd_ref(v, m);
        rq = s ? "R9" : ((m < 4) ? "R1" : "R2");
        fit_ref(r, 10, 1'b1, s, y, o);
        chk(rq, "aligned value", int'($signed(dout_a)), y);
        chk(rq, "aligned flag", int'(ovf_a), o);
        if (m < 2 && !s) chk("R3", "floor-type flag", int'(ovf_a), 0);
        fit_ref(r, 11, 1'b1, s, y, o);
        chk(s ? "R9" : "R4", "carry value", int'($signed(dout_w)), y);
        chk(s ? "R9" : "R4", "carry flag", int'(ovf_w), o);
        cw = int'($signed(dout_w));
        if (cw > 511) cw = 511;
        if (cw < -512) cw = -512;
        if (!s) chk("R6", "align equivalence", int'($signed(dout_a)), cw);
        fit_ref(r, 13, 1'b1, s, y, o);
        chk(s ? "R9" : "R8", "extended value", int'($signed(dout_e)), y);
        chk(s ? "R9" : "R8", "extended flag", int'(ovf_e), o);
        fit_ref(r, 8, 1'b1, s, y, o);
        chk(s ? "R9" : "R5", "saturated value", int'($signed(dout_n)), y);
        chk(s ? "R9" : "R5", "saturated flag", int'(ovf_n), o);
        fit_ref(r, 8, 1'b0, s, y, o);
        chk(s ? "R9" : "R7", "trimmed value", int'($signed(dout_t)), y);
        chk(s ? "R9" : "R7", "trimmed flag", int'(ovf_t), o);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        din = 16'h7FFF;
        mode = 3'd2;
        sym_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", "reset dout", int'(dout_a), 0);
        chk("R10", "reset ovf", int'(ovf_a), 0);
        chk("R10", "reset dout trim", int'(dout_t), 0);
        rst = 1'b0;
    endtask

    task automatic test_ties();
        int vals[10] = '{32, -32, 96, -96, 31, -31, 33, -33, 0, -1};
        foreach (vals[i])
            for (int m = 0; m < 8; m++) run_vec(vals[i], m, 1'b0);
    endtask

    task automatic test_limits();
        int vals[10] = '{32767, -32768, 32736, 32735, -32737, -32736, 8191, 8160, -8192, -8193};
        foreach (vals[i])
            for (int m = 0; m < 8; m++) begin
                run_vec(vals[i], m, 1'b0);
                run_vec(vals[i], m, 1'b1);
            end
    endtask

    task automatic test_sym_overlap();
        // R9 with R5: saturate to the minimum then clamp
        run_vec(-32768, 0, 1'b1);
        chk("R9", "sat then clamp", int'($signed(dout_n)), -127);
        chk("R9", "sat then clamp flag", int'(ovf_n), 1);
        run_vec(-32768, 0, 1'b0);
        chk("R9", "min passes when off", int'($signed(dout_a)), -512);
    endtask

    task automatic test_latency();
        // R10: output follows the previous edge's inputs
        run_vec(640, 0, 1'b0);
        @(negedge clk);
        din = 16'd1280;
        #1;
        chk("R10", "holds until edge", int'($signed(dout_a)), 10);
        @(negedge clk);
        chk("R10", "updates after edge", int'($signed(dout_a)), 20);
    endtask

    task automatic test_sweep();
        for (int m = 0; m < 8; m++)
            for (int s = 0; s < 2; s++)
                for (int v = -32768; v <= 32767; v += 97)
                    run_vec(v, m, s[0]);
    endtask

    initial begin
        #(5.0 * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        test_reset();
        test_ties();
        test_limits();
        test_sym_overlap();
        test_latency();
        test_sweep();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule